// File: doc/BRIEF.md
# Configurable External Interrupt Controller

The block watches a set of external interrupt lines, up to thirty-two, and raises one interrupt output per line toward the CPU when the condition chosen for that line is seen. Each line can watch for a low level, a high level, a rising edge, a falling edge or either edge. Every input is brought into the clock domain through a two-stage synchroniser. Edges are found by comparing the synchronised sample with the sample one cycle older.

A detected event is held in a sticky status bit that software clears by writing a one to it. The status bit is ANDed with a per-line enable to form the interrupt output. Enables are changed only through a set register and a clear register, so one line's enable can change without touching the others. A monitor register shows the synchronised level of every line.

Software uses a plain 32-bit register port with separate read and write strobes, a byte address and write data. Read data is registered and appears on the cycle after the read strobe. The port has no stream traffic, so it has no valid/ready handshake. Every access completes in one cycle, and the port never stalls.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, all enables, all detect-status bits, all sense fields and every `irq_out` bit are zero, and a read of the enable register at byte offset 0x04 returns zero.
- R2: Each line passes through two synchronising flops. The level monitor at byte offset 0x104 returns the synchronised level of line n in bit n.
- R3: Line n has a configuration word at byte offset 0x180 + 4*n. Its bits [5:0] hold the sense code, and its bits [31:6] read as zero. The codes are 0x01 low level, 0x02 high level, 0x04 falling edge, 0x08 rising edge and 0x0C either edge. Any other code detects nothing.
- R4: In a level mode, the status bit is set on every cycle the condition holds. A clear that arrives while the condition still holds leaves the bit set.
- R5: In an edge mode, a matching transition of the synchronised input sets the status bit. The bit stays set until software clears it, even after the input returns to its earlier level.
- R6: A write to the detect status at byte offset 0x100 clears each bit written as 1 and leaves each bit written as 0 unchanged. A new event in the same cycle as a clear wins, and the bit stays set. Reading 0x100 returns the status bits.
- R7: Writing a 1 to bit n of the enable-set register at byte offset 0x08 enables line n. Bits written as 0 leave their enables unchanged.
- R8: Writing a 1 to bit n at byte offset 0x04 disables line n. Bits written as 0 leave their enables unchanged. A read of 0x04 returns the enable mask.
- R9: `irq_out[n]` and bit n of the request register at byte offset 0x00 equal status[n] AND enable[n]. A write to 0x00 changes nothing.
- R10: `bus_rdata` is updated on the clock edge where `bus_rd` is sampled high, so it is valid from the next cycle. An unmapped address reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_lines | input | NUM_LINES | Asynchronous external interrupt lines |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_out | output | NUM_LINES | Per-line interrupt request toward the CPU |

## Verification
A change on `ext_lines` reaches the monitor register after two clock edges. The same change reaches the detect status and `irq_out` on the third edge: two synchroniser flops, then the status flop. Enable and clear writes take effect on the edge that samples the strobe, and read data is due one edge after the read strobe. The bench drives all inputs on falling edges. It keeps a cycle-accurate expectation of synchroniser, status, enable and configuration state, updated on the same rising edges as the design, and it compares `irq_out` and every read result on the following falling edge, so every comparison falls in the cycle its result is due.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int ADDR_W   = 9;
  localparam int DATA_W   = 32;
  localparam int SENSE_W  = 6;
  localparam int WADDR_W  = ADDR_W - 2;

  // word offsets (byte offset / 4)
  localparam logic [WADDR_W-1:0] W_REQ    = 7'h00;
  localparam logic [WADDR_W-1:0] W_EN_CLR = 7'h01;
  localparam logic [WADDR_W-1:0] W_EN_SET = 7'h02;
  localparam logic [WADDR_W-1:0] W_DET    = 7'h40;
  localparam logic [WADDR_W-1:0] W_MON    = 7'h41;

  typedef enum logic [SENSE_W-1:0] {
    SNS_OFF  = 6'h00,
    SNS_LOW  = 6'h01,
    SNS_HIGH = 6'h02,
    SNS_FALL = 6'h04,
    SNS_RISE = 6'h08,
    SNS_BOTH = 6'h0C
  } sense_e;

  function automatic logic sense_hit(input logic [SENSE_W-1:0] code,
                                     input logic now, input logic prev);
    logic hit;
    case (code)
      SNS_LOW:  hit = !now;
      SNS_HIGH: hit = now;
      SNS_FALL: hit = prev && !now;
      SNS_RISE: hit = now && !prev;
      SNS_BOTH: hit = now ^ prev;
      default:  hit = 1'b0;
    endcase
    return hit;
  endfunction

  function automatic logic sense_known(input logic [SENSE_W-1:0] code);
    return (code == SNS_LOW) || (code == SNS_HIGH) || (code == SNS_FALL) ||
           (code == SNS_RISE) || (code == SNS_BOTH);
  endfunction
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] dout_prev
);
  localparam int NST = (STAGES < 2) ? 2 : STAGES;

  logic [WIDTH-1:0] chain [NST];
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= din;
  end

  for (genvar s = 1; s < NST; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= chain[NST-1];
  end

  assign dout      = chain[NST-1];
  assign dout_prev = prev_q;

  // prev sample is the synced sample one cycle older (R2)
  assert_prev_tracks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (dout_prev == $past(dout)));
endmodule

// File: rtl/eic_line.sv
module eic_line
  import eic_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               samp_now,
  input  logic               samp_prev,
  input  logic               cfg_we,
  input  logic [SENSE_W-1:0] cfg_wdata,
  input  logic               clr,
  output logic [SENSE_W-1:0] cfg_q,
  output logic               status_q
);
  logic hit;

  always_comb hit = sense_hit(cfg_q, samp_now, samp_prev);

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata;
  end

  // a new event wins over a simultaneous clear
  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= 1'b0;
    else        status_q <= (status_q && !clr) || hit;
  end

  // latched event survives until a clear (R5)
  assert_status_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && !clr) |=> status_q);

  // unknown codes never raise an event (R3)
  assert_unknown_code_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sense_known(cfg_q) && !status_q) |=> !status_q);

  // level-high condition held means status set next cycle (R4)
  assert_level_high_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q == SNS_HIGH && samp_now) |=> status_q);
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eic_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] ext_lines,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic [NUM_LINES-1:0] irq_out
);
  localparam int MAXL  = 32;
  localparam int IDX_W = $clog2(MAXL);

  logic [WADDR_W-1:0]   waddr;
  logic                 cfg_sel;
  logic [IDX_W-1:0]     cfg_idx;
  logic [NUM_LINES-1:0] samp, samp_prev;
  logic [NUM_LINES-1:0] status, en_q, clr_vec;
  logic [SENSE_W-1:0]   cfg_all [MAXL];
  logic [DATA_W-1:0]    rd_val;

  assign waddr   = bus_addr[ADDR_W-1:2];
  assign cfg_sel = (waddr[WADDR_W-1:WADDR_W-2] == 2'b11);
  assign cfg_idx = waddr[IDX_W-1:0];

  eic_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(ext_lines),
    .dout(samp), .dout_prev(samp_prev)
  );

  assign clr_vec = (bus_wr && waddr == W_DET) ? bus_wdata[NUM_LINES-1:0] : '0;

  for (genvar n = 0; n < MAXL; n++) begin : g_line
    if (n < NUM_LINES) begin : g_used
      logic [SENSE_W-1:0] cfg_n;
      eic_line u_line (
        .clk(clk), .rst_n(rst_n),
        .samp_now(samp[n]), .samp_prev(samp_prev[n]),
        .cfg_we(bus_wr && cfg_sel && cfg_idx == IDX_W'(n)),
        .cfg_wdata(bus_wdata[SENSE_W-1:0]),
        .clr(clr_vec[n]),
        .cfg_q(cfg_n), .status_q(status[n])
      );
      assign cfg_all[n] = cfg_n;
    end else begin : g_unused
      assign cfg_all[n] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= '0;
    else if (bus_wr && waddr == W_EN_SET) en_q <= en_q | bus_wdata[NUM_LINES-1:0];
    else if (bus_wr && waddr == W_EN_CLR) en_q <= en_q & ~bus_wdata[NUM_LINES-1:0];
  end

  assign irq_out = status & en_q;

  always_comb begin
    rd_val = '0;
    if (cfg_sel)               rd_val[SENSE_W-1:0]   = cfg_all[cfg_idx];
    else if (waddr == W_REQ)   rd_val[NUM_LINES-1:0] = status & en_q;
    else if (waddr == W_EN_CLR) rd_val[NUM_LINES-1:0] = en_q;
    else if (waddr == W_DET)   rd_val[NUM_LINES-1:0] = status;
    else if (waddr == W_MON)   rd_val[NUM_LINES-1:0] = samp;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  // enable-set write leaves written bits enabled (R7)
  assert_en_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && waddr == W_EN_SET) |=>
      ((en_q & $past(bus_wdata[NUM_LINES-1:0])) == $past(bus_wdata[NUM_LINES-1:0])));

  // enable-clear write drops written bits (R8)
  assert_en_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && waddr == W_EN_CLR) |=> ((en_q & $past(bus_wdata[NUM_LINES-1:0])) == '0));

  // config readback has zero upper bits (R3)
  assert_cfg_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && cfg_sel) |=> (bus_rdata[DATA_W-1:SENSE_W] == '0));

  // data read is captured on the strobe edge (R10)
  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd && $past(rst_n)) |=> $stable(bus_rdata));
endmodule

// File: tb/ext_irq_ctrl_tb_top.sv
module ext_irq_ctrl_tb_top;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  lines = '0;
  logic          rd = 1'b0, wr = 1'b0;
  logic [8:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [N-1:0]  irq;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ext_irq_ctrl #(.NUM_LINES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .ext_lines(lines), .bus_rd(rd), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_out(irq)
  );

  // expectation state, written from the requirements
  logic [N-1:0] m_s1, m_s2, m_pv, m_st, m_en;
  logic [5:0]   m_cfg [N];
  logic [31:0]  m_rd;

  function automatic logic f_hit(input logic [5:0] c, input logic now, input logic pv);
    case (c)
      6'h01: return !now;
      6'h02: return now;
      6'h04: return pv && !now;
      6'h08: return now && !pv;
      6'h0C: return now != pv;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] f_read(input logic [8:0] a);
    if (a >= 9'h180) return {26'd0, m_cfg[a[6:2]]};
    case (a[8:2])
      7'h00: return m_st & m_en;
      7'h01: return m_en;
      7'h40: return m_st;
      7'h41: return m_s2;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_pv <= '0; m_st <= '0; m_en <= '0; m_rd <= '0;
      for (int i = 0; i < N; i++) m_cfg[i] <= '0;
    end else begin
      m_s1 <= lines; m_s2 <= m_s1; m_pv <= m_s2;
      for (int i = 0; i < N; i++) begin
        m_st[i] <= (m_st[i] && !(wr && addr[8:2] == 7'h40 && wdata[i]))
                   || f_hit(m_cfg[i], m_s2[i], m_pv[i]);
        if (wr && addr >= 9'h180 && addr[6:2] == 5'(i)) m_cfg[i] <= wdata[5:0];
      end
      if (wr && addr[8:2] == 7'h02)      m_en <= m_en | wdata;
      else if (wr && addr[8:2] == 7'h01) m_en <= m_en & ~wdata;
      if (rd) m_rd <= f_read(addr);
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // interrupt outputs compared on every falling edge (R9)
  always @(negedge clk) if (rst_n && !done) check("R9 irq_out", irq, m_st & m_en);

  task automatic bwrite(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bread(input string tag, input logic [8:0] a, output logic [31:0] v);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0;
    check(tag, rdata, m_rd);
    v = rdata;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  initial begin
    #3_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    idle(3); rst_n = 1'b1; idle(1);
    // R1 reset state
    check("R1 irq after reset", irq, 32'd0);
    bread("R1 enables", 9'h004, v); check("R1 enables literal", v, 32'd0);
    // R3 config readback masks upper bits
    bwrite(9'h18C, 32'hFFFF_FFC8);
    bread("R3 cfg", 9'h18C, v); check("R3 cfg literal", v, 32'h08);
    // R2 monitor, R5 rising edge latched
    lines[3] = 1'b1; idle(4);
    bread("R2 monitor", 9'h104, v); check("R2 monitor literal", v, 32'h8);
    bread("R5 status", 9'h100, v); check("R5 status literal", v, 32'h8);
    lines[3] = 1'b0; idle(4);
    bread("R5 held", 9'h100, v); check("R5 held literal", v, 32'h8);
    // R7 enable set, R9 request
    bwrite(9'h008, 32'h8);
    bread("R7 enable", 9'h004, v); check("R7 enable literal", v, 32'h8);
    check("R9 irq literal", irq, 32'h8);
    bread("R9 request", 9'h000, v); check("R9 request literal", v, 32'h8);
    // R6 write-zero no effect, write-one clears
    bwrite(9'h100, 32'h0);
    bread("R6 zero write", 9'h100, v); check("R6 zero literal", v, 32'h8);
    bwrite(9'h100, 32'h8);
    bread("R6 clear", 9'h100, v); check("R6 clear literal", v, 32'h0);
    // R4 level held survives clear
    bwrite(9'h194, 32'h02); lines[5] = 1'b1; idle(4);
    bwrite(9'h100, 32'h20);
    bread("R4 level", 9'h100, v); check("R4 level literal", v[5], 32'd1);
    // R3 unknown code detects nothing
    bwrite(9'h19C, 32'h03);
    for (int i = 0; i < 6; i++) begin lines[7] = ~lines[7]; idle(2); end
    bread("R3 unknown", 9'h100, v); check("R3 unknown literal", v[7], 32'd0);
    // R8 enable clear
    bwrite(9'h004, 32'h8);
    bread("R8 enable clr", 9'h004, v); check("R8 literal", v, 32'h0);
    // R9 write to request ignored, R10 unmapped reads zero
    bwrite(9'h000, 32'hFFFF_FFFF);
    bread("R9 req write ignored", 9'h004, v); check("R9 ignored literal", v, 32'h0);
    bread("R10 unmapped", 9'h040, v); check("R10 literal", v, 32'h0);
    // constrained random phase
    for (int it = 0; it < 3000; it++) begin
      int op;
      logic [5:0] code;
      lines = lines ^ ($urandom() & $urandom() & $urandom());
      op = int'($urandom_range(0, 9));
      case ($urandom_range(0, 6))
        0: code = 6'h01; 1: code = 6'h02; 2: code = 6'h04;
        3: code = 6'h08; 4: code = 6'h0C; 5: code = 6'h00;
        default: code = 6'($urandom());
      endcase
      case (op)
        0: bwrite(9'h180 + 9'(4 * $urandom_range(0, 31)), {26'h3FF_FFFF, code});
        1: bwrite(9'h008, $urandom());
        2: bwrite(9'h004, $urandom() & $urandom());
        3: bwrite(9'h100, $urandom());
        4: bread("R6 rand status", 9'h100, v);
        5: bread("R2 rand monitor", 9'h104, v);
        6: bread("R9 rand request", 9'h000, v);
        7: bread("R3 rand cfg", 9'h180 + 9'(4 * $urandom_range(0, 31)), v);
        8: bread("R8 rand enables", 9'h004, v);
        default: idle(1);
      endcase
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule